// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable pin-level model of a 16-bit-wide static memory with an asynchronous control interface. All controls are active low. There is a chip select, a write strobe, an output gate, and one enable for each byte lane. The bidirectional data bus is split into an input bus, an output bus and one drive flag per byte lane. A surrounding pad or test wrapper turns these into a tri-state bus.

The model decodes the control pins into a mode. It keeps the low lane (bits 7:0) and the high lane (bits 15:8) in separate storage, and it decides for each half of the bus whether it is driven or left floating. Write timing is abstracted to a sampling clock:

- The write window of a lane is open while chip select, write strobe and that lane's enable are all low.
- While the window is open, the address and data are sampled on every clock edge.
- The lane is written on the first clock edge after the window closes, using the last sampled values.

The address width is a parameter. A value of 15 gives the full 32,768-word organisation; the default of 10 keeps elaboration small. Storage is not cleared by reset.

Top module: `bytelane_sram`

## Requirements
- R1: Storage is organised as 2**AW words of two independent 8-bit lanes. Lane 0 is bus bits 7:0, enabled by `lb_n`. Lane 1 is bus bits 15:8, enabled by `ub_n`.
- R2: A lane's write window is open when `ce_n`, `we_n` and that lane's enable are all low. The address and data are sampled at every rising clock edge inside the window. The lane is written on the first rising edge at which the window is seen closed, with the last sampled address and data.
- R3: A lane whose enable is high during a write keeps its stored byte unchanged.
- R4: `dq_oe[0]` is 1 exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `lb_n`=0, and `dq_oe[1]` follows the same rule with `ub_n`. `dq_out` shows the stored word at `addr` combinationally, with no clock delay.
- R5: While `ce_n`=0 and `we_n`=0, both bits of `dq_oe` are 0.
- R6: While `ce_n`=1, `standby` is 1, both bits of `dq_oe` are 0, and no lane is written whatever the other pins do.
- R7: With `ce_n`=0 and `we_n`=1, `oe_n`=1 or both byte enables high leave both bits of `dq_oe` at 0.
- R8: Whichever of `ce_n`, `we_n` or the lane enable rises first ends that lane's write. Bus values applied after that point are not stored.
- R9: After reset, with `ce_n`=1, `standby` is 1 and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for write capture |
| rst_n | input | 1 | Asynchronous active-low reset of the capture state |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| lb_n | input | 1 | Low lane enable, active low |
| ub_n | input | 1 | High lane enable, active low |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data bus as seen by the memory |
| dq_out | output | 16 | Data the memory would drive |
| dq_oe | output | 2 | Per-lane drive flag; bit 0 is the low lane |
| standby | output | 1 | High while deselected (power-down) |

## Verification
The output flags and read data are combinational, so they are due in the same cycle as the control or address change. The bench drives inputs on falling edges and samples 1 ns later, before the next rising edge.

A write only becomes visible one rising edge after its window closes. Every write sequence therefore closes its window on a falling edge and lets one more rising edge pass before any read of that address.

The sequences for window-ending order and for multi-cycle windows hold the bus through known rising edges. This means the expected byte is the one present at the last edge inside the window.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int AW     = 10,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic                lb_n,
  input  logic                ub_n,
  input  logic [AW-1:0]       addr,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] dq_out,
  output logic [1:0]          dq_oe,
  output logic                standby
);
  localparam int DEPTH = 1 << AW;

  logic [1:0] be_n;
  logic       rd_sel;

  assign be_n    = {ub_n, lb_n};
  assign rd_sel  = ~ce_n & ~oe_n & we_n;
  assign standby = ce_n;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] dat_q;
    logic [AW-1:0]     adr_q;
    logic              open_q;
    logic              open;

    assign open = ~ce_n & ~we_n & ~be_n[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        dat_q  <= '0;
        adr_q  <= '0;
      end else begin
        open_q <= open;
        if (open) begin
          dat_q <= dq_in[l*LANE_W +: LANE_W];
          adr_q <= addr;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (open_q && !open) mem[adr_q] <= dat_q;
    end

    assign dq_out[l*LANE_W +: LANE_W] = mem[addr];
    assign dq_oe[l] = rd_sel & ~be_n[l];
  end

  assert_wr_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> (dq_oe == 2'b00));
  assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (standby && dq_oe == 2'b00));
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || (lb_n && ub_n)) |-> (dq_oe == 2'b00));
  assert_drive_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 2'b00) |-> (!ce_n && we_n && !oe_n));
endmodule

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  localparam int AW = 10;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, lb_n = 1, ub_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe;
  logic standby;

  int checks = 0, errors = 0;
  logic [7:0] sh_lo [1 << AW];
  logic [7:0] sh_hi [1 << AW];
  bit ok_lo [1 << AW];
  bit ok_hi [1 << AW];

  always #5 clk = ~clk;

  bytelane_sram #(.AW(AW), .LANE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby));

  function automatic logic [1:0] exp_oe(logic c, logic o, logic w, logic l, logic u);
    logic rd = !c && !o && w;
    return {rd && !u, rd && !l};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic l, logic u, int len);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = $urandom_range(0, 1); lb_n = l; ub_n = u; addr = a; dq_in = d;
    #1 chk("R5", dq_oe, 2'b00);
    repeat (len - 1) @(negedge clk);
    idle();
    if (!l) begin sh_lo[a] = d[7:0]; ok_lo[a] = 1; end
    if (!u) begin sh_hi[a] = d[15:8]; ok_hi[a] = 1; end
  endtask

  task automatic do_read(string req, logic [AW-1:0] a, logic l, logic u);
    @(negedge clk);
    ce_n = 0; we_n = 1; oe_n = 0; lb_n = l; ub_n = u; addr = a;
    #1;
    chk("R4", dq_oe, exp_oe(0, 0, 1, l, u));
    if (ok_lo[a]) chk(req, dq_out[7:0], sh_lo[a]);
    if (ok_hi[a]) chk(req, dq_out[15:8], sh_hi[a]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", {standby, dq_oe}, 3'b100);

    // R1 R3 lane independence
    do_write(10'd5, 16'hA1B2, 0, 0, 1);
    do_read("R1", 10'd5, 0, 0);
    do_write(10'd5, 16'h77C3, 0, 1, 1);
    do_read("R3", 10'd5, 0, 0);
    do_write(10'd5, 16'h9E00, 1, 0, 2);
    do_read("R3", 10'd5, 0, 0);
    do_write(TOP[AW-1:0], 16'h1357, 0, 0, 1);
    do_read("R1", TOP[AW-1:0], 0, 0);

    // R2 multi-cycle window: last sampled data wins
    @(negedge clk);
    ce_n = 0; we_n = 0; lb_n = 0; ub_n = 0; addr = 10'd9; dq_in = 16'h1111;
    @(negedge clk); dq_in = 16'h2222;
    @(negedge clk); dq_in = 16'h3333;
    idle();
    sh_lo[9] = 8'h33; sh_hi[9] = 8'h33; ok_lo[9] = 1; ok_hi[9] = 1;
    do_read("R2", 10'd9, 0, 0);

    // R8 lane enable rises first; later bus values not stored
    @(negedge clk);
    ce_n = 0; we_n = 0; lb_n = 0; ub_n = 1; addr = 10'd12; dq_in = 16'h00AA;
    @(negedge clk); lb_n = 1; dq_in = 16'h0055;
    @(negedge clk); dq_in = 16'h00CC;
    idle();
    sh_lo[12] = 8'hAA; ok_lo[12] = 1;
    do_read("R8", 10'd12, 0, 0);

    // R8 chip select rises first
    @(negedge clk);
    ce_n = 0; we_n = 0; lb_n = 0; ub_n = 0; addr = 10'd13; dq_in = 16'hBEEF;
    @(negedge clk); ce_n = 1; dq_in = 16'h0000;
    @(negedge clk); we_n = 1;
    idle();
    sh_lo[13] = 8'hEF; sh_hi[13] = 8'hBE; ok_lo[13] = 1; ok_hi[13] = 1;
    do_read("R8", 10'd13, 0, 0);

    // R6 standby ignores a write attempt
    @(negedge clk);
    ce_n = 1; we_n = 0; oe_n = 0; lb_n = 0; ub_n = 0; addr = 10'd5; dq_in = 16'hFFFF;
    #1 chk("R6", {standby, dq_oe}, 3'b100);
    @(negedge clk);
    idle();
    do_read("R6", 10'd5, 0, 0);

    // R7 outputs-disabled states
    @(negedge clk);
    ce_n = 0; we_n = 1; oe_n = 1; lb_n = 0; ub_n = 0;
    #1 chk("R7", dq_oe, 2'b00);
    @(negedge clk);
    oe_n = 0; lb_n = 1; ub_n = 1;
    #1 chk("R7", dq_oe, 2'b00);
    do_read("R4", 10'd5, 1, 0);
    do_read("R4", 10'd5, 0, 1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 3) == 0) ? TOP[AW-1:0] - AW'($urandom_range(0, 3))
                                       : AW'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: begin
          logic l, u;
          l = $urandom_range(0, 1); u = $urandom_range(0, 1);
          if (l && u) l = 0;
          do_write(a, 16'($urandom), l, u, $urandom_range(1, 3));
        end
        1: do_read("R4", a, $urandom_range(0, 1), $urandom_range(0, 1));
        2: begin
          logic c, o, l, u;
          @(negedge clk);
          c = $urandom_range(0, 1); o = $urandom_range(0, 1);
          l = $urandom_range(0, 1); u = $urandom_range(0, 1);
          ce_n = c; we_n = 1; oe_n = o; lb_n = l; ub_n = u; addr = a;
          #1 chk("R7", dq_oe, exp_oe(c, o, 1, l, u));
        end
        default: begin
          @(negedge clk);
          ce_n = 1; we_n = $urandom_range(0, 1); oe_n = $urandom_range(0, 1);
          lb_n = $urandom_range(0, 1); ub_n = $urandom_range(0, 1);
          addr = a; dq_in = 16'($urandom);
          #1 chk("R6", {standby, dq_oe}, 3'b100);
        end
      endcase
    end
    idle();
    for (int a = 0; a < 16; a++) do_read("R1", AW'(a), 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule